// File: doc/BRIEF.md
# Converter Synchronization Controller

This block decides when the decimation filter is cleared, when the delta-sigma modulator is frozen, when the serial port is shut off, and when a one-cycle sync strobe is issued on the system clock. Several converters that see the same sync event restart their filters together and stay aligned. Two sync sources are accepted. The first is an active-low sync pin that arrives asynchronously. The second is a sync command that the serial interface decodes. The serial interface also supplies one-cycle indications of serial clock edges, already moved into the system clock domain.

A low level on the pin clears the filter, freezes the modulator and disables the serial interface. All three stay active for as long as the pin is low. When the pin returns high, the strobe fires on the next system clock edge. A command clears the filter for one cycle. It then freezes the modulator until the serial interface reports its next serial clock edge, and the strobe fires on the system clock edge that follows that report. A falling edge on the pin always takes priority over the command path.

States and transitions:
- **IDLE**: rest state.
  - Pin falling edge goes to PIN_HOLD.
  - Command goes to CMD_FRST.
- **PIN_HOLD**: filter clear, modulator hold and serial disable are all active.
  - Synchronized pin high goes to FIRE.
  - Commands and serial edges are ignored here.
- **CMD_FRST**: one cycle of filter clear, with the modulator held.
  - Pin falling edge goes to PIN_HOLD.
  - A new command stays in CMD_FRST.
  - A serial edge goes to FIRE.
  - Otherwise the state moves to CMD_WAIT.
- **CMD_WAIT**: modulator held.
  - Pin falling edge goes to PIN_HOLD.
  - A new command goes to CMD_FRST.
  - A serial edge goes to FIRE.
- **FIRE**: the strobe is high for one cycle and every hold is released.
  - Pin falling edge goes to PIN_HOLD.
  - A command goes to CMD_FRST.
  - Otherwise the state returns to IDLE.

Top module: `conv_sync_ctrl`

## Requirements
- R1: After reset, which is asynchronous and active-low, and in every cycle while it is applied, all four outputs are 0. A reset applied while a command sync is pending cancels it.
- R2: The pin passes through a synchronizer of SYNC_STAGES flops, 2 by default. Outputs respond on the SYNC_STAGES+1-th rising clock edge at which the new pin level is present. Before that edge they are unchanged.
- R3: While the synchronized pin is low, filt_rst, mod_hold and sif_disable are all 1 and sync_pulse is 0. During this time cmd_sync and sclk_edge have no effect.
- R4: After the pin returns high, sync_pulse is 1 for exactly one cycle, following the R2 latency. In that same cycle filt_rst, mod_hold and sif_disable are 0. All four outputs are 0 in the cycle after.
- R5: A cmd_sync sampled outside pin hold gives filt_rst=1 for exactly the next cycle. It also raises mod_hold, and sif_disable stays 0.
- R6: After a command, mod_hold stays 1 until an sclk_edge is sampled, however long that takes. sync_pulse is then 1 for one cycle, with mod_hold 0 in that same cycle.
- R7: An sclk_edge sampled in the cycle right after the command counts as the first following edge, so sync_pulse appears in the next cycle. An sclk_edge sampled together with cmd_sync belongs to the command itself and does not end the hold.
- R8: A pin falling edge during a pending command sync abandons the command. The pin hold sequence of R3 and R4 runs instead.
- R9: A new cmd_sync while a command sync is pending restarts it. filt_rst is pulsed again and the hold waits for a fresh sclk_edge.
- R10: sync_pulse is never 1 together with filt_rst, mod_hold or sif_disable. Every sync_pulse is preceded by a cycle with mod_hold=1.
- R11: If a pin falling edge and cmd_sync are seen in the same cycle, the pin wins and the block enters pin hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin_n | input | 1 | Active-low sync pin, asynchronous to clk |
| cmd_sync | input | 1 | One-cycle pulse: sync command decoded, coincident with its last serial clock edge |
| sclk_edge | input | 1 | One-cycle pulse: a serial clock data edge was seen |
| filt_rst | output | 1 | Decimation filter clear |
| mod_hold | output | 1 | Modulator hold |
| sif_disable | output | 1 | Serial interface disable |
| sync_pulse | output | 1 | One-cycle synchronization strobe |

## Verification
Pin falling-edge detection and command acceptance can occur in the same cycle. The bench provokes this by lowering the pin two cycles ahead, so that the synchronized falling edge lines up with a cmd_sync pulse. It then expects the pin hold pattern with no filter-clear-only cycle in between. The pin overriding a pending command is also exercised: the pin is lowered while the command waits for its serial edge. So are a serial edge arriving together with, or right after, the command, and a repeated command. Each of these cases is judged against a per-cycle table of expected output patterns.

// File: rtl/conv_sync_pkg.sv
package conv_sync_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PIN_HOLD = 3'd1,
        ST_CMD_FRST = 3'd2,
        ST_CMD_WAIT = 3'd3,
        ST_FIRE     = 3'd4
    } sync_state_e;

    typedef struct packed {
        logic filt_rst;
        logic mod_hold;
        logic sif_off;
        logic pulse;
    } sync_ctl_t;

    localparam sync_ctl_t CTL_NONE = '{filt_rst: 1'b0, mod_hold: 1'b0, sif_off: 1'b0, pulse: 1'b0};

endpackage

// File: rtl/sync_pin_stage.sv
module sync_pin_stage #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_lvl,
    output logic pin_fall
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain_q;
    logic          lvl_d1_q;

    genvar g;
    generate
        for (g = 0; g <= LAST; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d1_q <= 1'b1;
        else        lvl_d1_q <= chain_q[LAST];
    end

    assign pin_lvl  = chain_q[LAST];
    assign pin_fall = lvl_d1_q & ~chain_q[LAST];

    // R2
    fall_is_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fall |=> !lvl_d1_q);

endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
    import conv_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_lvl,
    input  logic      pin_fall,
    input  logic      cmd_sync,
    input  logic      sclk_edge,
    output sync_ctl_t ctl
);
    sync_state_e cur_q, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= ST_IDLE;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_IDLE: begin
                if (pin_fall)      nxt = ST_PIN_HOLD;
                else if (cmd_sync) nxt = ST_CMD_FRST;
            end
            ST_PIN_HOLD: begin
                if (pin_lvl)       nxt = ST_FIRE;
            end
            ST_CMD_FRST: begin
                if (pin_fall)       nxt = ST_PIN_HOLD;
                else if (cmd_sync)  nxt = ST_CMD_FRST;
                else if (sclk_edge) nxt = ST_FIRE;
                else                nxt = ST_CMD_WAIT;
            end
            ST_CMD_WAIT: begin
                if (pin_fall)       nxt = ST_PIN_HOLD;
                else if (cmd_sync)  nxt = ST_CMD_FRST;
                else if (sclk_edge) nxt = ST_FIRE;
            end
            ST_FIRE: begin
                if (pin_fall)      nxt = ST_PIN_HOLD;
                else if (cmd_sync) nxt = ST_CMD_FRST;
                else               nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl = CTL_NONE;
        unique case (cur_q)
            ST_IDLE:     ctl = CTL_NONE;
            ST_PIN_HOLD: begin
                ctl.filt_rst = 1'b1;
                ctl.mod_hold = 1'b1;
                ctl.sif_off  = 1'b1;
            end
            ST_CMD_FRST: begin
                ctl.filt_rst = 1'b1;
                ctl.mod_hold = 1'b1;
            end
            ST_CMD_WAIT: ctl.mod_hold = 1'b1;
            ST_FIRE:     ctl.pulse    = 1'b1;
            default:     ctl = CTL_NONE;
        endcase
    end

    // R5
    cmd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sync && !pin_fall && cur_q != ST_PIN_HOLD) |=> (ctl.filt_rst && ctl.mod_hold && !ctl.sif_off));

    // R6
    hold_until_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_CMD_WAIT && !sclk_edge && !pin_fall && !cmd_sync) |=> (ctl.mod_hold && !ctl.pulse));

    // R4
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pulse |=> !ctl.pulse);

    // R8
    pin_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fall |=> ctl.sif_off);

    // R3
    hold_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.sif_off && !pin_lvl) |=> (ctl.sif_off && ctl.filt_rst && ctl.mod_hold));

    // R10
    hold_before_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pulse |-> $past(ctl.mod_hold));

endmodule

// File: rtl/conv_sync_ctrl.sv
module conv_sync_ctrl
    import conv_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_pin_n,
    input  logic cmd_sync,
    input  logic sclk_edge,
    output logic filt_rst,
    output logic mod_hold,
    output logic sif_disable,
    output logic sync_pulse
);
    logic      pin_lvl;
    logic      pin_fall;
    sync_ctl_t ctl;

    sync_pin_stage #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (sync_pin_n),
        .pin_lvl  (pin_lvl),
        .pin_fall (pin_fall)
    );

    sync_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_lvl),
        .pin_fall  (pin_fall),
        .cmd_sync  (cmd_sync),
        .sclk_edge (sclk_edge),
        .ctl       (ctl)
    );

    assign filt_rst    = ctl.filt_rst;
    assign mod_hold    = ctl.mod_hold;
    assign sif_disable = ctl.sif_off;
    assign sync_pulse  = ctl.pulse;

endmodule

// File: tb/conv_sync_ctrl_test.sv
module conv_sync_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 28;

    // row = {pin_n, cmd_sync, sclk_edge, filt_rst, mod_hold, sif_disable, sync_pulse}
    localparam logic [6:0] VEC [NROWS] = '{
        7'b100_0000, 7'b110_1100, 7'b100_0100, 7'b100_0100,
        7'b101_0001, 7'b100_0000, 7'b111_1100, 7'b101_0001,
        7'b100_0000, 7'b110_1100, 7'b100_0100, 7'b110_1100,
        7'b100_0100, 7'b000_0100, 7'b000_0100, 7'b000_1110,
        7'b011_1110, 7'b100_1110, 7'b100_1110, 7'b100_0001,
        7'b100_0000, 7'b000_0000, 7'b000_0000, 7'b010_1110,
        7'b100_1110, 7'b100_1110, 7'b100_0001, 7'b100_0000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b1;
    logic cmd = 1'b0;
    logic sclk = 1'b0;
    logic filt_rst, mod_hold, sif_disable, sync_pulse;

    int checks = 0;
    int failures = 0;
    int excl_viol = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_sync_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sync_pin_n(pin_n), .cmd_sync(cmd),
        .sclk_edge(sclk), .filt_rst(filt_rst), .mod_hold(mod_hold),
        .sif_disable(sif_disable), .sync_pulse(sync_pulse)
    );

    function automatic string row_tag(int r);
        case (r)
            1, 2, 3:         return "R5";
            4, 5:            return "R6";
            6, 7:            return "R7";
            11, 12:          return "R9";
            13, 14, 21, 22:  return "R2";
            15:              return "R8";
            16, 17, 18:      return "R3";
            19, 20, 26, 27:  return "R4";
            23, 24, 25:      return "R11";
            default:         return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: outputs {filt,hold,sif,pulse} actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic drive(logic p, logic c, logic s);
        @(negedge clk);
        pin_n = p; cmd = c; sclk = s;
        @(posedge clk);
        #2;
    endtask

    // R10 monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && sync_pulse && (filt_rst || mod_hold || sif_disable)) excl_viol++;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        // R1: outputs held at zero during reset
        check("R1", {filt_rst, mod_hold, sif_disable, sync_pulse}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1", {filt_rst, mod_hold, sif_disable, sync_pulse}, 4'b0000);

        for (int r = 0; r < NROWS; r++) begin
            drive(VEC[r][6], VEC[r][5], VEC[r][4]);
            check(row_tag(r), {filt_rst, mod_hold, sif_disable, sync_pulse}, VEC[r][3:0]);
        end

        // R6: a long wait for the serial edge keeps the modulator held
        drive(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 20; k++) drive(1'b1, 1'b0, 1'b0);
        check("R6", {filt_rst, mod_hold, sif_disable, sync_pulse}, 4'b0100);
        drive(1'b1, 1'b0, 1'b1);
        check("R6", {filt_rst, mod_hold, sif_disable, sync_pulse}, 4'b0001);
        drive(1'b1, 1'b0, 1'b0);

        // R1: reset during a pending command cancels it
        drive(1'b1, 1'b1, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", {filt_rst, mod_hold, sif_disable, sync_pulse}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 1'b1);
        check("R1", {filt_rst, mod_hold, sif_disable, sync_pulse}, 4'b0000);

        // R10: exclusivity monitor over the whole run
        checks++;
        if (excl_viol != 0) begin
            failures++;
            $display("FAIL R10: pulse overlap count actual=%0d expected=0", excl_viol);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule